// File: doc/BRIEF.md
# SDRAM Command Spacing Gate

This block sits between an SDRAM command sequencer and the SDRAM command pins. The sequencer offers one command per cycle together with a bank number over a valid/ready handshake. The gate lowers ready until three programmable minimum spacings, counted in SDRAM clock cycles, have elapsed:
- the delay from a row activation to a column READ or WRITE on the same bank;
- the spacing between activations of two different banks;
- the recovery time after a mode register load, during which nothing at all may issue.

Each accepted command appears on a registered output one cycle later.

The spacings come from a one-byte configuration register that holds compact codes. In each 2-bit code, a zero selects the longest spacing. The register has two reset inputs. A cold reset loads the slowest settings. A warm reset clears every running timing window but keeps the programmed codes. Both resets are synchronous and active low.

Top module: `sdram_cmd_gate`

## Requirements
- R1: While `cold_rst_n` is low, `req_ready` and `out_valid` are 0. From the first clock edge with `cold_rst_n` low, `cfg_rdata` reads 0x00, which means activation-to-column 4 cycles, bank-to-bank activation 4 cycles and mode recovery 2 cycles.
- R2: While `warm_rst_n` is low, `req_ready` and `out_valid` are 0 and `cfg_rdata` holds its value. After a warm reset, no earlier timing window is still in force.
- R3: The configuration byte holds the activation-to-column code in bits 7:6, the mode recovery code in bit 5 and the bank-to-bank activation code in bits 4:3. Bits 2:0 read 0. A write takes effect on the clock edge where `cfg_we` is 1, and is ignored while either reset is low.
- R4: Codes 1, 2 and 3 in the activation-to-column field give 1, 2 and 3 cycles, and code 0 gives 4 cycles. Suppose an activation to bank b is accepted in cycle t with a spacing of D cycles. Then READ (code 2) and WRITE (code 3) to bank b have `req_ready` low until cycle t+D.
- R5: The activation-to-column windows are kept per bank. An activation of one bank never holds back READ or WRITE to another bank.
- R6: Suppose an activation to bank b is accepted in cycle t with a bank-to-bank code that gives D cycles (decoded as in R4). Then an activation (code 1) to any bank other than b has `req_ready` low until cycle t+D. A new activation to bank b itself is not held back by this rule.
- R7: The mode recovery code gives 1 cycle for value 1 and 2 cycles for value 0. After a mode register load (code 4) is accepted in cycle t, every command has `req_ready` low until cycle t+D.
- R8: A command accepted in cycle t (`req_valid` and `req_ready` both 1) appears in cycle t+1 with `out_valid` 1 and the same `out_cmd` and `out_bank`. In a cycle after no acceptance, `out_valid` is 0, `out_cmd` is NOP (code 0) and `out_bank` is 0.
- R9: NOP (code 0) and codes 5 to 7 (precharge, refresh and other commands) are subject only to the mode recovery rule of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | SDRAM clock |
| cold_rst_n | input | 1 | Cold reset, active low; loads the slowest codes |
| warm_rst_n | input | 1 | Warm reset, active low; keeps the codes |
| cfg_we | input | 1 | Configuration byte write enable |
| cfg_wdata | input | 8 | Configuration byte write data |
| cfg_rdata | output | 8 | Configuration byte read back |
| req_valid | input | 1 | Sequencer offers a command |
| req_cmd | input | 3 | Offered command code |
| req_bank | input | BANK_W | Bank of the offered command |
| req_ready | output | 1 | Gate accepts the offered command this cycle |
| out_valid | output | 1 | A command is driven to the SDRAM this cycle |
| out_cmd | output | 3 | Command code to the SDRAM |
| out_bank | output | BANK_W | Bank to the SDRAM |

## Verification
The assertions check these properties on every cycle:
- the cold-reset value of the configuration byte;
- its stability through a warm reset;
- that every output command follows an acceptance;
- that ready drops in the cycle right after an activation or mode load when the slowest code is programmed.

The full length of each window, and its dependence on each code, can only be shown by the bench's reference model. The same holds for:
- the independence of banks;
- the exemption of same-bank activations;
- the clearing of windows by a warm reset.

The reference model tracks release times as absolute cycle numbers and compares ready, the outputs and the configuration byte in every cycle, across directed sequences and a long random run with reprogramming.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;
  // width of every spacing counter
  localparam int TW = 3;

  // configuration byte field positions
  localparam int CFG_RCD_LO = 6;
  localparam int CFG_RSC_BIT = 5;
  localparam int CFG_RRD_LO = 3;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_MRS = 3'd4,
    CMD_PRE = 3'd5,
    CMD_REF = 3'd6,
    CMD_OTH = 3'd7
  } cmd_e;

  // 2-bit code: 1..3 literal, 0 means 4 cycles
  function automatic logic [TW-1:0] span2(input logic [1:0] code);
    span2 = (code == 2'd0) ? 3'd4 : {1'b0, code};
  endfunction

  // 1-bit code: 1 means 1 cycle, 0 means 2 cycles
  function automatic logic [TW-1:0] span1(input logic code);
    span1 = code ? 3'd1 : 3'd2;
  endfunction

  // counter preload: a window of N cycles loads N-1
  function automatic logic [TW-1:0] preload(input logic [TW-1:0] span);
    preload = span - 3'd1;
  endfunction
endpackage

// File: rtl/sdram_gate_cfg.sv
module sdram_gate_cfg
  import sdram_gate_pkg::*;
(
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       warm_rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [1:0] rcd_code,
  output logic       rsc_code,
  output logic [1:0] rrd_code,
  output logic [7:0] rdata
);
  logic [1:0] rcd_q, rrd_q;
  logic       rsc_q;
  logic       wr_ok;
  logic [2:0] unused_low;

  assign unused_low = wdata[2:0];
  assign wr_ok = we && cold_rst_n && warm_rst_n;

  always_ff @(posedge clk) begin
    if (!cold_rst_n) begin
      rcd_q <= 2'd0;
      rsc_q <= 1'b0;
      rrd_q <= 2'd0;
    end else if (wr_ok) begin
      rcd_q <= wdata[CFG_RCD_LO +: 2];
      rsc_q <= wdata[CFG_RSC_BIT];
      rrd_q <= wdata[CFG_RRD_LO +: 2];
    end
  end

  assign rcd_code = rcd_q;
  assign rsc_code = rsc_q;
  assign rrd_code = rrd_q;

  always_comb begin
    rdata = 8'h00;
    rdata[CFG_RCD_LO +: 2] = rcd_q;
    rdata[CFG_RSC_BIT]     = rsc_q;
    rdata[CFG_RRD_LO +: 2] = rrd_q;
  end
endmodule

// File: rtl/sdram_gate_win.sv
module sdram_gate_win #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sdram_gate_banks.sv
module sdram_gate_banks
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              act_acc,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [TW-1:0]     load_val,
  output logic [NUM_BANKS-1:0] busy
);
  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit;
    assign hit = act_acc && (act_bank == BANK_W'(i));
    sdram_gate_win #(.CW(TW)) win_i (
      .clk(clk), .clr(clr), .load(hit), .load_val(load_val), .busy(busy[i])
    );
  end
endmodule

// File: rtl/sdram_gate_act.sv
module sdram_gate_act
  import sdram_gate_pkg::*;
#(
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              act_acc,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [TW-1:0]     load_val,
  input  logic [BANK_W-1:0] req_bank,
  output logic              block_other
);
  logic              busy;
  logic [BANK_W-1:0] last_bank;

  sdram_gate_win #(.CW(TW)) win_i (
    .clk(clk), .clr(clr), .load(act_acc), .load_val(load_val), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (clr)
      last_bank <= '0;
    else if (act_acc)
      last_bank <= act_bank;
  end

  assign block_other = busy && (req_bank != last_bank);
endmodule

// File: rtl/sdram_cmd_gate.sv
module sdram_cmd_gate
  import sdram_gate_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W = $clog2(NUM_BANKS)
) (
  input  logic              clk,
  input  logic              cold_rst_n,
  input  logic              warm_rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  output logic              req_ready,
  output logic              out_valid,
  output logic [2:0]        out_cmd,
  output logic [BANK_W-1:0] out_bank
);
  logic [1:0] rcd_code, rrd_code;
  logic       rsc_code;
  logic       clr;
  cmd_e       cmd_i;

  // named internal events
  logic                 accept;
  logic                 act_acc;
  logic                 mrs_acc;
  logic                 mrs_block;
  logic                 col_block;
  logic                 act_block;
  logic [NUM_BANKS-1:0] rcd_busy;

  assign clr   = !cold_rst_n || !warm_rst_n;
  assign cmd_i = cmd_e'(req_cmd);

  sdram_gate_cfg cfg_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .we(cfg_we), .wdata(cfg_wdata),
    .rcd_code(rcd_code), .rsc_code(rsc_code), .rrd_code(rrd_code),
    .rdata(cfg_rdata)
  );

  sdram_gate_banks #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) banks_i (
    .clk(clk), .clr(clr), .act_acc(act_acc), .act_bank(req_bank),
    .load_val(preload(span2(rcd_code))), .busy(rcd_busy)
  );

  sdram_gate_act #(.BANK_W(BANK_W)) act_i (
    .clk(clk), .clr(clr), .act_acc(act_acc), .act_bank(req_bank),
    .load_val(preload(span2(rrd_code))), .req_bank(req_bank),
    .block_other(act_block)
  );

  sdram_gate_win #(.CW(TW)) mrs_i (
    .clk(clk), .clr(clr), .load(mrs_acc),
    .load_val(preload(span1(rsc_code))), .busy(mrs_block)
  );

  assign col_block = ((cmd_i == CMD_RD) || (cmd_i == CMD_WR)) && rcd_busy[req_bank];

  always_comb begin
    req_ready = !clr && !mrs_block;
    if (col_block) req_ready = 1'b0;
    if ((cmd_i == CMD_ACT) && act_block) req_ready = 1'b0;
  end

  assign accept  = req_valid && req_ready;
  assign act_acc = accept && (cmd_i == CMD_ACT);
  assign mrs_acc = accept && (cmd_i == CMD_MRS);

  always_ff @(posedge clk) begin
    if (clr) begin
      out_valid <= 1'b0;
      out_cmd   <= CMD_NOP;
      out_bank  <= '0;
    end else begin
      out_valid <= accept;
      out_cmd   <= accept ? req_cmd : CMD_NOP;
      out_bank  <= accept ? req_bank : '0;
    end
  end
endmodule

// File: rtl/sdram_gate_chk.sv
module sdram_gate_chk #(
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              cold_rst_n,
  input logic              warm_rst_n,
  input logic [7:0]        cfg_rdata,
  input logic              req_valid,
  input logic [2:0]        req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic              req_ready,
  input logic              out_valid,
  input logic [2:0]        out_cmd
);
  logic cold_seen = 1'b0;
  logic acc;
  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    cold_seen <= !cold_rst_n;
    // R1
    if (cold_seen) begin
      cold_cfg_chk: assert (cfg_rdata == 8'h00)
        else $error("cfg not cleared by cold reset");
    end
  end

  // R2
  warm_keep_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !warm_rst_n |=> (cfg_rdata == $past(cfg_rdata)))
    else $error("cfg changed in warm reset");

  // R8
  out_src_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    out_valid |-> $past(acc))
    else $error("output without acceptance");

  // R8
  out_idle_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    !out_valid |-> (out_cmd == 3'd0))
    else $error("idle output not NOP");

  // R4
  rcd_slow_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (acc && req_cmd == 3'd1 && cfg_rdata[7:6] == 2'd0) |=>
      !(req_ready && (req_cmd == 3'd2 || req_cmd == 3'd3) && req_bank == $past(req_bank)))
    else $error("column command too early");

  // R6
  rrd_slow_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (acc && req_cmd == 3'd1 && cfg_rdata[4:3] == 2'd0) |=>
      !(req_ready && req_cmd == 3'd1 && req_bank != $past(req_bank)))
    else $error("second activation too early");

  // R7
  rsc_slow_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
    (acc && req_cmd == 3'd4 && !cfg_rdata[5]) |=> !req_ready)
    else $error("command inside mode recovery");
endmodule

bind sdram_cmd_gate sdram_gate_chk #(.BANK_W(BANK_W)) chk_i (
  .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_cmd(req_cmd),
  .req_bank(req_bank), .req_ready(req_ready), .out_valid(out_valid),
  .out_cmd(out_cmd)
);

// File: tb/sdram_cmd_gate_tb.sv
module sdram_cmd_gate_tb_top;
  localparam int NB = 4;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          cold_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = 8'h00;
  logic [7:0]    cfg_rdata;
  logic          req_valid = 1'b0;
  logic [2:0]    req_cmd = 3'd0;
  logic [BW-1:0] req_bank = '0;
  logic          req_ready, out_valid;
  logic [2:0]    out_cmd;
  logic [BW-1:0] out_bank;

  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sdram_cmd_gate #(.NUM_BANKS(NB)) dut_i (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
    .req_ready(req_ready), .out_valid(out_valid), .out_cmd(out_cmd),
    .out_bank(out_bank)
  );

  // reference model: release cycles as absolute numbers
  int   cyc = 0;
  int   col_free_at[NB];
  int   act_free_at = 0;
  int   any_free_at = 0;
  int   last_act = 0;
  byte  m_cfg = 0;
  logic m_ov = 1'b0;
  int   m_oc = 0, m_ob = 0;

  function automatic int cycles_of2(int code);
    return (code == 0) ? 4 : code;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic clear_windows();
    foreach (col_free_at[i]) col_free_at[i] = 0;
    act_free_at = 0;
    any_free_at = 0;
  endtask

  task automatic step(input logic c_n, input logic w_n, input logic v,
                      input int cmd, input int bank,
                      input logic we, input int wd);
    int    e_rdy;
    string tag;
    logic  acc;
    @(negedge clk);
    cold_rst_n = c_n; warm_rst_n = w_n; req_valid = v;
    req_cmd = 3'(cmd); req_bank = BW'(bank); cfg_we = we; cfg_wdata = 8'(wd);
    #1;
    check("R3 cfg", int'(cfg_rdata), int'(m_cfg) & 255);
    check("R8 out_valid", int'(out_valid), int'(m_ov));
    check("R8 out_cmd", int'(out_cmd), m_oc);
    check("R8 out_bank", int'(out_bank), m_ob);
    e_rdy = 1; tag = "R9 ready";
    if (!c_n) begin e_rdy = 0; tag = "R1 ready"; end
    else if (!w_n) begin e_rdy = 0; tag = "R2 ready"; end
    else if (cyc < any_free_at) begin e_rdy = 0; tag = "R7 ready"; end
    else if (cmd == 2 || cmd == 3) begin
      tag = "R4 R5 ready";
      if (cyc < col_free_at[bank]) e_rdy = 0;
    end else if (cmd == 1) begin
      tag = "R6 ready";
      if (bank != last_act && cyc < act_free_at) e_rdy = 0;
    end
    check(tag, int'(req_ready), e_rdy);
    acc = v && (e_rdy == 1);
    m_ov = acc; m_oc = acc ? cmd : 0; m_ob = acc ? bank : 0;
    if (!c_n) begin
      m_cfg = 0; clear_windows();
    end else if (!w_n) begin
      clear_windows();
    end else begin
      if (acc && cmd == 1) begin
        col_free_at[bank] = cyc + cycles_of2((int'(m_cfg) >> 6) & 3);
        act_free_at = cyc + cycles_of2((int'(m_cfg) >> 3) & 3);
        last_act = bank;
      end
      if (acc && cmd == 4) any_free_at = cyc + (((int'(m_cfg) >> 5) & 1) == 1 ? 1 : 2);
      if (we) m_cfg = byte'(wd & 8'hF8);
    end
    cyc++;
  endtask

  task automatic go(input int cmd, input int bank);
    step(1, 1, 1, cmd, bank, 0, 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic wcfg(input int wd);
    step(1, 1, 0, 0, 0, 1, wd);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_windows();
    // R1 cold reset, with a write attempt that must be ignored (R3)
    step(0, 1, 1, 1, 0, 0, 0);
    step(0, 1, 1, 2, 0, 1, 8'hFF);
    step(0, 1, 0, 0, 0, 0, 0);
    idle(2);
    // R4 slowest codes: ACT then READ same bank held 4 cycles
    go(1, 0);
    for (int i = 0; i < 5; i++) go(2, 0);
    // R6 activation of another bank held, same bank allowed
    go(1, 1);
    go(1, 2);
    go(1, 1);
    for (int i = 0; i < 4; i++) go(1, 3);
    // R5 other bank column unaffected
    go(1, 0);
    go(3, 2);
    go(2, 0);
    idle(4);
    // R7 mode recovery of 2 cycles blocks everything, R9 others pass
    go(4, 0);
    go(5, 1);
    go(6, 0);
    go(7, 3);
    go(0, 0);
    // R3 reprogram: rcd=1, rsc=1, rrd=2 -> 0x70
    wcfg(8'h77);
    go(1, 0);
    go(2, 0);
    go(1, 1);
    go(1, 1);
    go(4, 0);
    go(3, 1);
    // rcd=3, rsc=0, rrd=3 -> 0xD8
    wcfg(8'hD8);
    go(1, 2);
    for (int i = 0; i < 4; i++) go(3, 2);
    // R2 warm reset clears windows, keeps cfg, ignores writes
    go(1, 1);
    step(1, 0, 1, 2, 1, 1, 8'h00);
    go(2, 1);
    go(1, 1);
    go(1, 3);
    go(4, 0);
    step(1, 0, 0, 0, 0, 0, 0);
    go(5, 0);
    // random run with occasional reprogramming and resets
    for (int i = 0; i < 3000; i++) begin
      int r = int'($urandom_range(0, 99));
      if (r == 0) step(0, 1, 1, 1, 0, 0, 0);
      else if (r == 1) step(1, 0, 1, 2, 1, 1, int'($urandom_range(0, 255)));
      else if (r < 5) wcfg(int'($urandom_range(0, 255)));
      else step(1, 1, $urandom_range(0, 3) != 0, int'($urandom_range(0, 7)),
                int'($urandom_range(0, NB - 1)), 0, 0);
    end
    idle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule